// File: doc/BRIEF.md
# Partition Power-Up Sequencer

This block brings a single power partition and the peripheral inside it out of the off state. A single start pulse selects the partition. The block then steps through a fixed order: reset on, power on, clock on, clamps off, reset off. The partition's reset is taken first. If the partition's power status shows it is still off, the block sends a one-cycle power request and waits for the status bit. Once power is confirmed, the peripheral clock is turned on. After a guard interval the isolation clamps are released, and after a second guard interval reset is dropped and completion is signalled.

The guard intervals and the power wait limit are given in microseconds and turned into clock cycles from the clock frequency parameter. If power is not confirmed within the limit, the block sets a sticky error flag. The peripheral then stays in reset with its clock off, and the block goes back to idle. The clamp release is a one-hot pulse. Two partitions, chosen by parameter, have their clamp bits exchanged, because the clamp register of such a chip keeps that historical swap.

Top module: `pwr_partition_sequencer`

## Requirements
- R1: A start request accepted in idle asserts `periph_rst_o`, clears `periph_clk_en_o` and latches the partition index onto `pwr_idx_o`, all on the first clock edge. No power request is made while reset is low.
- R2: If the selected bit of `pwr_status_i` is already 1 on the second edge after start, no power request is issued, and `periph_clk_en_o` rises on that edge.
- R3: Otherwise `pwr_req_o` is high for exactly one cycle, starting on the second edge after start.
- R4: While waiting, `periph_clk_en_o` rises on the first edge at which the selected status bit is 1. Status bits of other partitions have no effect.
- R5: If the selected status bit stays 0 for TO_CYC cycles after the power request, `err_o` is set and the block returns to idle. `periph_rst_o` stays 1 and `periph_clk_en_o` stays 0. `err_o` holds until the next accepted start, which clears it on its first edge.
- R6: `clamp_o` pulses for one cycle, exactly GUARD_CYC cycles after `periph_clk_en_o` rises. The pulse is one-hot at bit `pwr_idx_o`, except that indices SWAP_A and SWAP_B drive each other's bit.
- R7: Exactly GUARD_CYC cycles after the clamp pulse, `periph_rst_o` falls and `done_o` pulses for one cycle, while `periph_clk_en_o` stays 1.
- R8: A start request while a sequence is running is ignored. `pwr_idx_o` and all event timing are unchanged.
- R9: GUARD_CYC = ceil(CLK_HZ·GUARD_US/10^6), with a minimum of 1. TO_CYC = ceil(CLK_HZ·TIMEOUT_US/10^6). The defaults are GUARD_US = 10 and TIMEOUT_US = 25000.
- R10: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start the power-up sequence |
| part_idx_i | input | IDX_W | Partition to power up, sampled with start |
| pwr_status_i | input | NUM_PART | Power-on status per partition |
| pwr_req_o | output | 1 | One-cycle power-on request |
| pwr_idx_o | output | IDX_W | Partition of the current or last sequence |
| periph_rst_o | output | 1 | Peripheral reset, active high |
| periph_clk_en_o | output | 1 | Peripheral clock enable |
| clamp_o | output | NUM_PART | One-cycle clamp release, one-hot |
| done_o | output | 1 | One-cycle success pulse |
| err_o | output | 1 | Sticky power timeout flag |

## Verification
The bench builds the block with CLK_HZ = 1 MHz, eight partitions and the clamp swap on partitions 3 and 5. Each guard interval is then 10 cycles and the power timeout is 25 000 cycles. This makes a full timeout, and the error and recovery that follow it, short enough to run directly. Both swapped clamp indices and an unswapped one are covered, along with the case where power is already on, a zero-delay power confirmation, and a start request arriving in the middle of a sequence.

// File: rtl/pps_pkg.sv
package pps_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ARM    = 3'd1,
    ST_PWR    = 3'd2,
    ST_GUARD1 = 3'd3,
    ST_GUARD2 = 3'd4
  } pps_state_e;

  // Cycles covering a span in microseconds, rounded up, never below one.
  function automatic longint unsigned us_to_cycles(longint unsigned hz,
                                                   longint unsigned us);
    longint unsigned c;
    c = (hz * us + 64'd999_999) / 64'd1_000_000;
    return (c == 0) ? 64'd1 : c;
  endfunction

  // Clamp bit that releases partition idx: a and b are exchanged.
  function automatic int unsigned clamp_bit(int unsigned idx,
                                            int unsigned a,
                                            int unsigned b);
    if (idx == a) return b;
    if (idx == b) return a;
    return idx;
  endfunction

  function automatic int unsigned width_for(longint unsigned v);
    int unsigned w;
    w = 1;
    while ((64'd1 << w) <= v) w++;
    return w;
  endfunction

endpackage

// File: rtl/pps_cycle_timer.sv
module pps_cycle_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             hit_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = en_i && (cnt_q == limit_i - CNT_W'(1));

  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> (cnt_q < limit_i));

endmodule

// File: rtl/pps_clamp_map.sv
module pps_clamp_map #(
  parameter int unsigned NUM_PART = 16,
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned SWAP_A   = 3,
  parameter int unsigned SWAP_B   = 4
) (
  input  logic [IDX_W-1:0]    idx_i,
  output logic [NUM_PART-1:0] mask_o
);
  import pps_pkg::*;

  for (genvar g = 0; g < NUM_PART; g++) begin : g_bit
    localparam int unsigned SRC = clamp_bit(g, SWAP_A, SWAP_B);
    assign mask_o[g] = (idx_i == IDX_W'(SRC));
  end

endmodule

// File: rtl/pwr_partition_sequencer.sv
module pwr_partition_sequencer #(
  parameter int unsigned NUM_PART   = 16,
  parameter longint unsigned CLK_HZ = 100_000_000,
  parameter int unsigned GUARD_US   = 10,
  parameter int unsigned TIMEOUT_US = 25_000,
  parameter int unsigned SWAP_A     = 3,
  parameter int unsigned SWAP_B     = 4,
  localparam int unsigned IDX_W     = (NUM_PART > 1) ? $clog2(NUM_PART) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [IDX_W-1:0]    part_idx_i,
  input  logic [NUM_PART-1:0] pwr_status_i,
  output logic                pwr_req_o,
  output logic [IDX_W-1:0]    pwr_idx_o,
  output logic                periph_rst_o,
  output logic                periph_clk_en_o,
  output logic [NUM_PART-1:0] clamp_o,
  output logic                done_o,
  output logic                err_o
);
  import pps_pkg::*;

  localparam longint unsigned GUARD_CYC = us_to_cycles(CLK_HZ, GUARD_US);
  localparam longint unsigned TO_CYC    = us_to_cycles(CLK_HZ, TIMEOUT_US);
  localparam longint unsigned MAX_CYC   = (TO_CYC > GUARD_CYC) ? TO_CYC : GUARD_CYC;
  localparam int unsigned     CNT_W     = width_for(MAX_CYC);

  pps_state_e state_q, state_d;
  logic [IDX_W-1:0]    idx_q;
  logic                req_q, rst_q, clk_en_q, done_q, err_q;
  logic [NUM_PART-1:0] clamp_q;

  // Named events
  logic                accept_start, pwr_seen, enter_clk, pwr_timeout;
  logic                guard1_end, guard2_end, need_req;
  logic                tmr_clr, tmr_en, tmr_hit;
  logic [CNT_W-1:0]    tmr_limit;
  logic [NUM_PART-1:0] clamp_mask;

  assign accept_start = (state_q == ST_IDLE) && start_i &&
                        (32'(part_idx_i) < NUM_PART);
  assign pwr_seen     = pwr_status_i[idx_q];
  assign need_req     = (state_q == ST_ARM) && !pwr_seen;
  assign enter_clk    = ((state_q == ST_ARM) || (state_q == ST_PWR)) && pwr_seen;
  assign pwr_timeout  = (state_q == ST_PWR) && !pwr_seen && tmr_hit;
  assign guard1_end   = (state_q == ST_GUARD1) && tmr_hit;
  assign guard2_end   = (state_q == ST_GUARD2) && tmr_hit;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept_start) state_d = ST_ARM;
      ST_ARM:    state_d = pwr_seen ? ST_GUARD1 : ST_PWR;
      ST_PWR:    if (pwr_seen) state_d = ST_GUARD1;
                 else if (tmr_hit) state_d = ST_IDLE;
      ST_GUARD1: if (tmr_hit) state_d = ST_GUARD2;
      ST_GUARD2: if (tmr_hit) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  assign tmr_clr   = (state_d != state_q);
  assign tmr_en    = (state_q == ST_PWR) || (state_q == ST_GUARD1) ||
                     (state_q == ST_GUARD2);
  assign tmr_limit = (state_q == ST_PWR) ? CNT_W'(TO_CYC) : CNT_W'(GUARD_CYC);

  pps_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (tmr_clr),
    .en_i    (tmr_en),
    .limit_i (tmr_limit),
    .hit_o   (tmr_hit)
  );

  pps_clamp_map #(
    .NUM_PART (NUM_PART),
    .IDX_W    (IDX_W),
    .SWAP_A   (SWAP_A),
    .SWAP_B   (SWAP_B)
  ) u_clamp (
    .idx_i  (idx_q),
    .mask_o (clamp_mask)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      req_q    <= 1'b0;
      rst_q    <= 1'b0;
      clk_en_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      clamp_q  <= '0;
    end else begin
      state_q <= state_d;
      req_q   <= need_req;
      done_q  <= guard2_end;
      clamp_q <= guard1_end ? clamp_mask : '0;
      if (accept_start) begin
        idx_q    <= part_idx_i;
        rst_q    <= 1'b1;
        clk_en_q <= 1'b0;
        err_q    <= 1'b0;
      end
      if (enter_clk)   clk_en_q <= 1'b1;
      if (pwr_timeout) err_q    <= 1'b1;
      if (guard2_end)  rst_q    <= 1'b0;
    end
  end

  assign pwr_req_o       = req_q;
  assign pwr_idx_o       = idx_q;
  assign periph_rst_o    = rst_q;
  assign periph_clk_en_o = clk_en_q;
  assign clamp_o         = clamp_q;
  assign done_o          = done_q;
  assign err_o           = err_q;

  // R1
  req_under_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_req_o |-> periph_rst_o);
  // R3
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_req_o |=> !pwr_req_o);
  // R4
  clk_after_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(periph_clk_en_o) |-> $past(pwr_status_i[idx_q]));
  // R5
  err_keeps_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (periph_rst_o && !periph_clk_en_o));
  // R6
  clamp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clamp_o));
  // R6
  clamp_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|clamp_o) |-> (periph_clk_en_o && periph_rst_o));
  // R7
  done_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!periph_rst_o && periph_clk_en_o));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R8
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> $stable(pwr_idx_o));

endmodule

// File: tb/tb_pwr_partition_sequencer.sv
module tb_pwr_partition_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int NP  = 8;
  localparam int HZ  = 1_000_000;
  localparam int SA  = 3;
  localparam int SB  = 5;
  localparam int G_EXP  = HZ / 100_000;   // 10 us in cycles (R9)
  localparam int TO_EXP = HZ / 40;        // 25 ms in cycles (R9)

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0] part_idx = '0;
  logic [NP-1:0] status = '0;
  logic pwr_req, prst, clk_en, done, err;
  logic [2:0] pidx;
  logic [NP-1:0] clamp;
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_partition_sequencer #(
    .NUM_PART(NP), .CLK_HZ(HZ), .SWAP_A(SA), .SWAP_B(SB)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .part_idx_i(part_idx),
    .pwr_status_i(status), .pwr_req_o(pwr_req), .pwr_idx_o(pidx),
    .periph_rst_o(prst), .periph_clk_en_o(clk_en), .clamp_o(clamp),
    .done_o(done), .err_o(err)
  );

  task automatic chk(input bit ok, input string tag, input longint act,
                     input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_mask(int idx);
    int b;
    b = (idx == SA) ? SB : (idx == SB) ? SA : idx;
    return 1 << b;
  endfunction

  task automatic run_seq(input int idx, input bit preset, input int delay,
                         input bit expect_to, input bit poke, input bit others);
    int req_first = -1, req_cnt = 0, clk_first = -1, clamp_first = -1;
    int clamp_cnt = 0, clamp_val = 0, done_first = -1, done_cnt = 0;
    int err_first = -1, rstlow_first = -1, end_c = -1, c = 0;
    bit idx_held = 1;
    status = others ? ~(NP'(1) << idx) : '0;
    if (preset) status[idx] = 1'b1;
    start = 1'b1;
    part_idx = 3'(idx);
    @(negedge clk);
    start = 1'b0;
    chk(prst == 1'b1, "R1 reset at start", prst, 1);
    chk(clk_en == 1'b0, "R1 clock off at start", clk_en, 0);
    chk(err == 1'b0, "R5 error cleared by start", err, 0);
    while ((end_c < 0 || c < end_c + 3) && c < 1 + TO_EXP + 10) begin
      if (pidx != 3'(idx)) idx_held = 0;
      if (pwr_req) begin if (req_first < 0) req_first = c; req_cnt++; end
      if (clk_en && clk_first < 0) clk_first = c;
      if (clamp != 0) begin
        if (clamp_first < 0) clamp_first = c;
        clamp_cnt++; clamp_val = int'(clamp);
      end
      if (done) begin if (done_first < 0) done_first = c; done_cnt++; end
      if (err && err_first < 0) err_first = c;
      if (!prst && rstlow_first < 0) rstlow_first = c;
      if (end_c < 0 && (done || err)) end_c = c;
      if (poke && c == 2) begin start = 1'b1; part_idx = 3'(idx ^ 1); end
      else start = 1'b0;
      if (!preset && !expect_to && c == 1 + delay) status[idx] = 1'b1;
      @(negedge clk);
      c++;
    end
    start = 1'b0;
    chk(idx_held, "R8/R1 index held", pidx, idx);
    if (preset) begin
      chk(req_cnt == 0, "R2 no request when already on", req_cnt, 0);
      chk(clk_first == 1, "R2 clock on second edge", clk_first, 1);
    end else begin
      chk(req_first == 1, "R3 request timing", req_first, 1);
      chk(req_cnt == 1, "R3 request width", req_cnt, 1);
    end
    if (!expect_to) begin
      if (!preset)
        chk(clk_first == 2 + delay, "R4 clock after status", clk_first, 2 + delay);
      chk(clamp_first == clk_first + G_EXP, "R6 clamp timing", clamp_first,
          clk_first + G_EXP);
      chk(clamp_cnt == 1 && clamp_val == exp_mask(idx), "R6 clamp pulse bit",
          clamp_val, exp_mask(idx));
      chk(done_first == clamp_first + G_EXP, "R7 done timing", done_first,
          clamp_first + G_EXP);
      chk(done_cnt == 1 && rstlow_first == done_first, "R7 reset release",
          rstlow_first, done_first);
      chk(clk_en == 1'b1 && err_first < 0, "R7 clock stays on", clk_en, 1);
    end else begin
      chk(err_first == 1 + TO_EXP, "R5 timeout timing", err_first, 1 + TO_EXP);
      chk(clk_first < 0 && prst == 1'b1 && done_cnt == 0,
          "R5 aborted with reset held", prst, 1);
      repeat (5) @(negedge clk);
      chk(err == 1'b1, "R5 error sticky", err, 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({pwr_req, prst, clk_en, done, err} == 5'b0 && clamp == '0,
        "R10 outputs in reset", {pwr_req, prst, clk_en, done, err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(prst == 1'b0 && pwr_req == 1'b0, "R10 idle after reset", prst, 0);
    run_seq(2, 0, 4, 0, 0, 0);   // R3 R4 R6 R7 plain bit
    run_seq(0, 1, 0, 0, 0, 0);   // R2 already powered
    run_seq(3, 0, 0, 0, 0, 0);   // R6 swapped index, zero delay
    run_seq(5, 0, 6, 0, 0, 1);   // R4 other status bits high, R6 swap
    run_seq(6, 0, 5, 0, 1, 0);   // R8 start while busy
    run_seq(1, 0, 0, 1, 0, 0);   // R5 timeout
    run_seq(7, 0, 2, 0, 0, 0);   // R5 recovery after error
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200_000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule